// File: doc/BRIEF.md
# Masked Priority Interrupt Requester

This block sits between a handful of peripheral event lines and a small processor core. Each source line gives a one-cycle pulse when its condition occurs. The block keeps one pending flag per source, but only for sources whose bit is set in a mask register that software writes. It offers the lowest-numbered pending source to the core as a binary vector together with a request flag. The core answers with an acknowledge, which retires that vector. The block then offers the next pending vector, or drops the request when nothing is left.

Vector 0 is reserved and never raised. In the intended system the sources are these:

| Vector | Source |
|---|---|
| 1 | receive queue holds data |
| 2 | receive queue at capacity |
| 3 | transmit queue holds data |
| 4 | transmit queue at capacity |
| 5 | keyboard delivered a character |
| 6 | timer wrapped |
| 7 | a direction button changed |

Pending flags do not count. A second pulse on a source that is still pending merges with the first one. The global interrupt enable belongs to the core and is not part of this block.

The output side is a two-state machine:
- ST_IDLE means no request is offered.
- ST_OFFER means irq_req is high and irq_vec is valid.

It has these transitions:
- "raise" goes from ST_IDLE to ST_OFFER when any enabled flag becomes pending.
- "advance" stays in ST_OFFER, either with the same vector or with the next one after an acknowledge.
- "drain" goes from ST_OFFER to ST_IDLE when the last flag is retired or masked away.
- "rest" stays in ST_IDLE.

Top module: `irq_requester`

## Requirements
- R1: After reset, irq_req is 0, irq_vec is 0, the mask is all zeros and no flag is pending. Source pulses seen before any mask write therefore raise nothing.
- R2: Mask bit i (1 = enabled) gates source i. A pulse on a source whose mask bit is 0 never makes it pending.
- R3: Source 0 never produces a request, whatever its mask bit holds.
- R4: A pulse on src_evt is captured at one rising edge. irq_req rises after the following rising edge, which makes two register stages. It is still low after the first edge.
- R5: While requesting, irq_vec is the binary number of the lowest-numbered pending source.
- R6: If irq_ack is high at a rising edge while irq_req is high, the flag of irq_vec clears at that edge. From that same edge the block offers the next lowest pending vector, or drops irq_req if none remains. If the clear coincides with a new pulse of the same source, the clear wins.
- R7: A pulse on a source whose flag is already pending is lost. A single acknowledge retires both pulses.
- R8: A mask write applies at its edge, and it discards the pending flag of every source whose new mask bit is 0.
- R9: irq_req is high exactly when some flag is pending. While irq_req is low, irq_vec is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_evt | input | N (8) | One-cycle event pulses, bit i is source i |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | N (8) | New mask value, 1 enables a source |
| irq_ack | input | 1 | Core accepts the offered vector |
| irq_req | output | 1 | Request offered to the core |
| irq_vec | output | $clog2(N) (3) | Number of the offered source |

## Verification
The delivery-order path is exercised with several patterns:
- Mask/event pairs with one source, with all sources, with the mask hiding the low sources, and with sparse overlaps. The acknowledge sequence must return the enabled pulsed sources in ascending order and then go quiet, which separates a correct lowest-first encoder from a highest-first or an unmasked one.
- A pulse on source 0 alone shows whether the reserved vector is properly excluded.
- A repeated pulse on a pending source, retired by one acknowledge, tells merging apart from counting.
- Mask writes that remove the currently offered source show whether a masked flag is discarded or merely hidden.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } req_state_e;

endpackage

// File: rtl/irqp_capture.sv
module irqp_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_evt,
    output logic [N-1:0] evt_q
);

    // First stage: register the raw event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= src_evt;
    end

endmodule

// File: rtl/irqp_prio.sv
module irqp_prio #(
    parameter int N  = 8,
    parameter int VW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [VW-1:0] idx
);

    logic [N-1:0] seen;
    logic [N-1:0] first;

    assign seen[0]  = req[0];
    assign first[0] = req[0];

    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_chain
            assign seen[g]  = seen[g-1] | req[g];
            assign first[g] = req[g] & ~seen[g-1];
        end
    endgenerate

    assign any = seen[N-1];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx = idx | VW'(i);
        end
    end

endmodule

// File: rtl/irqp_pending.sv
module irqp_pending #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_q,
    input  logic [N-1:0] mask_nxt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend_q,
    output logic [N-1:0] pend_nxt
);

    localparam logic [N-1:0] RESERVED = N'(1);

    logic [N-1:0] allow;

    // Vector 0 is reserved and can never be enabled.
    assign allow    = mask_nxt & ~RESERVED;
    // The clear wins over a coinciding set.
    assign pend_nxt = (pend_q | evt_q) & ~clr & allow;

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nxt;
    end

endmodule

// File: rtl/irq_requester.sv
module irq_requester
    import irqp_pkg::*;
#(
    parameter int N  = 8,
    parameter int VW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  src_evt,
    input  logic          mask_we,
    input  logic [N-1:0]  mask_wdata,
    input  logic          irq_ack,
    output logic          irq_req,
    output logic [VW-1:0] irq_vec
);

    req_state_e    state_q, state_d;
    logic [VW-1:0] vec_q, vec_d;
    logic [N-1:0]  mask_q, mask_nxt;
    logic [N-1:0]  evt_q;
    logic [N-1:0]  pend_q, pend_nxt;
    logic [N-1:0]  clr;
    logic          any_n;
    logic [VW-1:0] idx_n;
    logic          ack_hit;

    irqp_capture #(.N(N)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_evt (src_evt),
        .evt_q   (evt_q)
    );

    // Mask register; the value being written applies at its edge.
    assign mask_nxt = mask_we ? mask_wdata : mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_nxt;
    end

    assign ack_hit = irq_ack && (state_q == ST_OFFER);
    assign clr     = ack_hit ? (N'(1) << vec_q) : '0;

    irqp_pending #(.N(N)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_q    (evt_q),
        .mask_nxt (mask_nxt),
        .clr      (clr),
        .pend_q   (pend_q),
        .pend_nxt (pend_nxt)
    );

    irqp_prio #(.N(N), .VW(VW)) u_prio (
        .req (pend_nxt),
        .any (any_n),
        .idx (idx_n)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            vec_q   <= vec_d;
        end
    end

    // Next state and output values
    always_comb begin
        state_d = state_q;
        vec_d   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (any_n) begin          // raise
                    state_d = ST_OFFER;
                    vec_d   = idx_n;
                end else begin            // rest
                    state_d = ST_IDLE;
                end
            end
            ST_OFFER: begin
                if (any_n) begin          // advance
                    state_d = ST_OFFER;
                    vec_d   = idx_n;
                end else begin            // drain
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign irq_req = (state_q == ST_OFFER);
    assign irq_vec = vec_q;

endmodule

// File: rtl/irqp_checker.sv
module irqp_checker #(
    parameter int N  = 8,
    parameter int VW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_req,
    input logic [VW-1:0] irq_vec,
    input logic          irq_ack,
    input logic          mask_we,
    input logic [N-1:0]  mask_wdata,
    input logic [N-1:0]  mask_q,
    input logic [N-1:0]  pend_q
);

    logic [N-1:0] below;
    assign below = (N'(1) << irq_vec) - N'(1);

    AST_NO_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec != '0)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (pend_q == '0 && irq_vec == '0)); // R9

    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend_q[irq_vec] && (pend_q & below) == '0)); // R5

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !pend_q[$past(irq_vec)]); // R6

    AST_MASK_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> ((pend_q & ~$past(mask_wdata)) == '0)); // R8

    AST_MASKED_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~mask_q) == '0); // R2

endmodule

bind irq_requester irqp_checker #(.N(N), .VW(VW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .irq_ack    (irq_ack),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .mask_q     (mask_q),
    .pend_q     (pend_q)
);

// File: tb/sim_irq_requester.sv
module sim_irq_requester;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_evt = '0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       irq_ack = 1'b0;
    logic       irq_req;
    logic [2:0] irq_vec;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_requester u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_evt    (src_evt),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .irq_ack    (irq_ack),
        .irq_req    (irq_req),
        .irq_vec    (irq_vec)
    );

    // {mask, events}
    localparam logic [15:0] PAT [8] = '{
        {8'hFF, 8'h82}, {8'hFF, 8'hFE}, {8'h0F, 8'hF6}, {8'hA5, 8'hFF},
        {8'hFE, 8'h01}, {8'h40, 8'h40}, {8'hFF, 8'h10}, {8'h3C, 8'h28}
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual req/vec=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic write_mask(input logic [7:0] m);
        mask_we = 1'b1; mask_wdata = m;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] e);
        src_evt = e;
        @(negedge clk);
        src_evt = '0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", {irq_req, irq_vec}, 4'h0);

        // R1/R2: mask is zero after reset, so pulses raise nothing.
        pulse(8'hFE);
        @(negedge clk); @(negedge clk);
        chk("R1 R2 reset mask blocks", {irq_req, irq_vec}, 4'h0);

        // Table walk: lowest-first delivery, R4 latency, R6 retire, R9 idle.
        for (int p = 0; p < 8; p++) begin
            logic [7:0] m;
            logic [7:0] e;
            logic [7:0] exp_set;
            m = PAT[p][15:8];
            e = PAT[p][7:0];
            write_mask(8'h00);
            write_mask(m);
            pulse(e);
            exp_set = e & m & 8'hFE;
            chk("R4 not yet after first edge", {irq_req, irq_vec}, 4'h0);
            @(negedge clk);
            for (int k = 0; k < 8; k++) begin
                if (exp_set != 0) begin
                    int low;
                    low = 0;
                    for (int b = 7; b >= 0; b--) if (exp_set[b]) low = b;
                    chk("R5 R6 R2 lowest pending offered", {irq_req, irq_vec}, {1'b1, 3'(low)});
                    ack();
                    exp_set[low] = 1'b0;
                end
            end
            chk("R9 idle after drain", {irq_req, irq_vec}, 4'h0);
        end

        // R3: source 0 alone with full mask.
        write_mask(8'hFF);
        pulse(8'h01);
        @(negedge clk); @(negedge clk);
        chk("R3 source zero ignored", {irq_req, irq_vec}, 4'h0);

        // R7: repeated pulse while pending merges.
        pulse(8'h08);
        pulse(8'h08);
        @(negedge clk);
        chk("R7 single vector offered", {irq_req, irq_vec}, 4'hB);
        ack();
        chk("R7 second pulse lost", {irq_req, irq_vec}, 4'h0);

        // R8: mask writes discard pending flags.
        pulse(8'h24);
        @(negedge clk);
        chk("R8 before mask change", {irq_req, irq_vec}, 4'hA);
        write_mask(8'hFB);
        chk("R8 vec 2 discarded", {irq_req, irq_vec}, 4'hD);
        write_mask(8'hFF);
        chk("R8 discard is permanent", {irq_req, irq_vec}, 4'hD);
        write_mask(8'hDB);
        chk("R8 all discarded", {irq_req, irq_vec}, 4'h0);

        // R6: ack with no request has no effect on later delivery.
        write_mask(8'hFF);
        ack();
        pulse(8'h40);
        @(negedge clk);
        chk("R6 stray ack harmless", {irq_req, irq_vec}, 4'hE);
        ack();
        chk("R6 retired", {irq_req, irq_vec}, 4'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule